// File: doc/BRIEF.md
# Peak and Valley Tracking Slicer Core

This block is the digital half of a four-level baseband slicer. It holds two up/down level registers. The upper one follows the positive excursions of the filtered signal. The lower one follows the negative excursions. Each register feeds an external DAC whose output sets one slicer reference. A third register-derived value, the mean of the two levels, feeds a centre DAC. Three external comparators report on every clock whether the signal is above the upper, the centre and the lower reference. From these results the block nudges the levels outward, lets them relax slowly inward, and registers a 2-bit symbol.

A 2-bit mode input selects one of four modes: standby, hold, slow acquisition or fast acquisition. Standby parks both levels at mid-scale and forces the symbol to zero. Hold freezes the levels and the pacing counters. The two acquisition modes differ only in how often an outward step may be taken. A track-inhibit input freezes both levels without stopping the pacing counters or the symbol.

Top module: `pvtrack_core`

## Requirements
- R1: While reset is asserted and right after it, both levels and the centre level read mid-scale (2^(LVL_W-1), 128 for 8 bits) and both symbol bits are 0.
- R2: mode_sel = 2'b00 (standby) loads both levels with mid-scale, clears the step and decay pacing counters, and sets the symbol to 2'b00 at the next clock edge.
- R3: mode_sel = 2'b11 (fast acquisition) raises the upper level by one on every edge where above_pk is 1, and lowers the lower level by one on every edge where above_vl is 0.
- R4: mode_sel = 2'b10 (slow acquisition) allows an outward step only on every SLOW_DIV-th edge spent in acquisition modes. The first such edge is the SLOW_DIV-th one after standby or reset.
- R5: On every DECAY_DIV-th edge spent in acquisition modes, each level that is not stepping outward on that edge moves one step toward the other level. This happens only when the upper level exceeds the lower level by at least 2 before the edge.
- R6: mode_sel = 2'b01 (hold) keeps both levels and both pacing counters unchanged.
- R7: With trk_inh = 1 in an acquisition mode, both levels stay unchanged and the pacing counters keep counting.
- R8: The upper level saturates at 2^LVL_W-1 and the lower level saturates at 0; neither wraps.
- R9: The upper level is never below the lower level.
- R10: Outside standby, the symbol {sym_hi, sym_lo} is registered on each edge as follows: 00 when above_vl is 0; otherwise 11 when above_pk is 1; otherwise 10 when above_ctr is 1; otherwise 01.
- R11: ctr_lvl equals floor((pk_lvl + vl_lvl) / 2) at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 standby, 01 hold, 10 slow acquisition, 11 fast acquisition |
| trk_inh | input | 1 | 1 freezes both levels |
| above_pk | input | 1 | Signal is above the upper reference |
| above_ctr | input | 1 | Signal is above the centre reference |
| above_vl | input | 1 | Signal is above the lower reference |
| pk_lvl | output | LVL_W | Upper level, code for the upper reference DAC |
| vl_lvl | output | LVL_W | Lower level, code for the lower reference DAC |
| ctr_lvl | output | LVL_W | Mean of the two levels, code for the centre DAC |
| sym_hi | output | 1 | Symbol MSB |
| sym_lo | output | 1 | Symbol LSB |

## Verification
The bench builds the core with LVL_W = 8, SLOW_DIV = 4 and DECAY_DIV = 16. It keeps the full 8-bit range, so both saturation rails are reached by a fast ramp of about 130 edges. The shortened step and decay periods let the slow-mode step cadence be seen within a few edges. They also let a full-range inward decay, from 255/0 down to a gap of one code, finish in about two thousand edges. In that run the tie rule on a gap below 2 and the ordering of the two levels are both exercised.

// File: rtl/pvtrack_pkg.sv
package pvtrack_pkg;

  typedef enum logic [1:0] {
    MODE_STBY = 2'b00,
    MODE_HOLD = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_FAST = 2'b11
  } trk_mode_e;

  // Symbol from the three comparator decisions; lower reference has priority.
  function automatic logic [1:0] sym_of(input logic abv_pk, input logic abv_ctr,
                                        input logic abv_vl);
    logic [1:0] s;
    if (!abv_vl)      s = 2'b00;
    else if (abv_pk)  s = 2'b11;
    else if (abv_ctr) s = 2'b10;
    else              s = 2'b01;
    return s;
  endfunction

  function automatic logic is_acq(input trk_mode_e m);
    return (m == MODE_SLOW) || (m == MODE_FAST);
  endfunction

endpackage

// File: rtl/pvtrack_pace.sv
module pvtrack_pace
  import pvtrack_pkg::*;
#(
  parameter int SLOW_DIV  = 8,
  parameter int DECAY_DIV = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  trk_mode_e mode,
  output logic      step_tick,
  output logic      decay_tick
);
  localparam int SW = (SLOW_DIV  > 1) ? $clog2(SLOW_DIV)  : 1;
  localparam int DW = (DECAY_DIV > 1) ? $clog2(DECAY_DIV) : 1;
  localparam logic [SW-1:0] SLOW_LAST  = SW'(SLOW_DIV - 1);
  localparam logic [DW-1:0] DECAY_LAST = DW'(DECAY_DIV - 1);

  logic [SW-1:0] slow_cnt;
  logic [DW-1:0] decay_cnt;
  logic          acq;

  assign acq = is_acq(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_cnt  <= '0;
      decay_cnt <= '0;
    end else if (mode == MODE_STBY) begin
      slow_cnt  <= '0;
      decay_cnt <= '0;
    end else if (acq) begin
      slow_cnt  <= (slow_cnt  == SLOW_LAST)  ? '0 : slow_cnt  + 1'b1;
      decay_cnt <= (decay_cnt == DECAY_LAST) ? '0 : decay_cnt + 1'b1;
    end
  end

  assign step_tick  = (mode == MODE_FAST) ||
                      ((mode == MODE_SLOW) && (slow_cnt == SLOW_LAST));
  assign decay_tick = acq && (decay_cnt == DECAY_LAST);

endmodule

// File: rtl/pvtrack_level.sv
module pvtrack_level #(
  parameter int LVL_W   = 8,
  parameter bit IS_PEAK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             step_tick,
  input  logic             decay_tick,
  input  logic             outward,
  input  logic             gap_ok,
  output logic [LVL_W-1:0] lvl,
  output logic             trk_evt,
  output logic             dcy_evt
);
  localparam logic [LVL_W-1:0] MID  = LVL_W'(1) << (LVL_W - 1);
  localparam logic [LVL_W-1:0] LMAX = '1;

  function automatic logic [LVL_W-1:0] inc_sat(input logic [LVL_W-1:0] v);
    return (v == LMAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [LVL_W-1:0] dec_sat(input logic [LVL_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic [LVL_W-1:0] out_val, in_val;

  generate
    if (IS_PEAK) begin : g_upper
      assign out_val = inc_sat(lvl);
      assign in_val  = dec_sat(lvl);
    end else begin : g_lower
      assign out_val = dec_sat(lvl);
      assign in_val  = inc_sat(lvl);
    end
  endgenerate

  assign trk_evt = run && step_tick && outward;
  assign dcy_evt = run && decay_tick && gap_ok && !trk_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl <= MID;
    else if (clear)    lvl <= MID;
    else if (trk_evt)  lvl <= out_val;
    else if (dcy_evt)  lvl <= in_val;
  end

endmodule

// File: rtl/pvtrack_slicer.sv
module pvtrack_slicer
  import pvtrack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       above_pk,
  input  logic       above_ctr,
  input  logic       above_vl,
  output logic [1:0] sym
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sym <= 2'b00;
    else if (!enable) sym <= 2'b00;
    else              sym <= sym_of(above_pk, above_ctr, above_vl);
  end
endmodule

// File: rtl/pvtrack_core.sv
module pvtrack_core
  import pvtrack_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int SLOW_DIV  = 8,
  parameter int DECAY_DIV = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             trk_inh,
  input  logic             above_pk,
  input  logic             above_ctr,
  input  logic             above_vl,
  output logic [LVL_W-1:0] pk_lvl,
  output logic [LVL_W-1:0] vl_lvl,
  output logic [LVL_W-1:0] ctr_lvl,
  output logic             sym_hi,
  output logic             sym_lo
);
  trk_mode_e    mode;
  logic         step_tick, decay_tick;
  logic         run, clear, gap_ok;
  logic         pk_trk, pk_dcy, vl_trk, vl_dcy;
  logic [1:0]   sym;
  logic [LVL_W:0] gap, sum;

  assign mode  = trk_mode_e'(mode_sel);
  assign clear = (mode == MODE_STBY);
  assign run   = is_acq(mode) && !trk_inh;

  assign gap    = {1'b0, pk_lvl} - {1'b0, vl_lvl};
  assign gap_ok = (gap >= (LVL_W+1)'(2)) && !gap[LVL_W];

  pvtrack_pace #(.SLOW_DIV(SLOW_DIV), .DECAY_DIV(DECAY_DIV)) pace_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .step_tick(step_tick), .decay_tick(decay_tick)
  );

  pvtrack_level #(.LVL_W(LVL_W), .IS_PEAK(1'b1)) upper_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
    .step_tick(step_tick), .decay_tick(decay_tick),
    .outward(above_pk), .gap_ok(gap_ok),
    .lvl(pk_lvl), .trk_evt(pk_trk), .dcy_evt(pk_dcy)
  );

  pvtrack_level #(.LVL_W(LVL_W), .IS_PEAK(1'b0)) lower_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
    .step_tick(step_tick), .decay_tick(decay_tick),
    .outward(!above_vl), .gap_ok(gap_ok),
    .lvl(vl_lvl), .trk_evt(vl_trk), .dcy_evt(vl_dcy)
  );

  pvtrack_slicer slicer_i (
    .clk(clk), .rst_n(rst_n), .enable(!clear),
    .above_pk(above_pk), .above_ctr(above_ctr), .above_vl(above_vl),
    .sym(sym)
  );

  assign sum     = {1'b0, pk_lvl} + {1'b0, vl_lvl};
  assign ctr_lvl = sum[LVL_W:1];
  assign sym_hi  = sym[1];
  assign sym_lo  = sym[0];

endmodule

// File: rtl/pvtrack_chk.sv
module pvtrack_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic             trk_inh,
  input logic             above_pk,
  input logic             above_vl,
  input logic [LVL_W-1:0] pk_lvl,
  input logic [LVL_W-1:0] vl_lvl,
  input logic             sym_hi,
  input logic             sym_lo,
  input logic             pk_trk,
  input logic             vl_trk
);
  localparam logic [LVL_W-1:0] MID  = LVL_W'(1) << (LVL_W - 1);
  localparam logic [LVL_W-1:0] LMAX = '1;

  // R2
  stby_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b00 |=> (pk_lvl == MID) && (vl_lvl == MID) && !sym_hi && !sym_lo);

  // R3
  fast_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) && !trk_inh && above_pk && (pk_lvl != LMAX)
      |=> pk_lvl == $past(pk_lvl) + 1'b1);

  // R6
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |=> $stable(pk_lvl) && $stable(vl_lvl));

  // R6
  hold_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |-> !pk_trk && !vl_trk);

  // R7
  inh_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk_inh && (mode_sel != 2'b00) |=> $stable(pk_lvl) && $stable(vl_lvl));

  // R8
  pk_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_lvl == LMAX |=> pk_lvl != '0);

  // R8
  vl_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_lvl == '0 |=> vl_lvl != LMAX);

  // R9
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_lvl >= vl_lvl);

  // R10
  sym_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b00) && !above_vl |=> !sym_hi && !sym_lo);

endmodule

bind pvtrack_core pvtrack_chk #(.LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trk_inh(trk_inh),
  .above_pk(above_pk), .above_vl(above_vl),
  .pk_lvl(pk_lvl), .vl_lvl(vl_lvl), .sym_hi(sym_hi), .sym_lo(sym_lo),
  .pk_trk(pk_trk), .vl_trk(vl_trk)
);

// File: tb/pvtrack_core_tb_top.sv
module pvtrack_core_tb_top;
  localparam int CLK_P  = 10;
  localparam int LW     = 8;
  localparam int SDIV   = 4;
  localparam int DDIV   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic          trk_inh = 1'b0, above_pk = 1'b0, above_ctr = 1'b0, above_vl = 1'b0;
  logic [LW-1:0] pk_lvl, vl_lvl, ctr_lvl;
  logic          sym_hi, sym_lo;

  int checks = 0, errors = 0;
  int m_pk = 128, m_vl = 128, m_sc = 0, m_dc = 0, m_sym = 0;

  always #(CLK_P/2) clk = ~clk;

  pvtrack_core #(.LVL_W(LW), .SLOW_DIV(SDIV), .DECAY_DIV(DDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trk_inh(trk_inh),
    .above_pk(above_pk), .above_ctr(above_ctr), .above_vl(above_vl),
    .pk_lvl(pk_lvl), .vl_lvl(vl_lvl), .ctr_lvl(ctr_lvl),
    .sym_hi(sym_hi), .sym_lo(sym_lo)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected next state, written from the requirement text.
  task automatic model_edge(input logic [1:0] m, input bit inh, apk, actr, avl);
    bit acq, step, dec, run, gap2;
    int npk, nvl;
    if (m == 2'b00) begin
      m_pk = 128; m_vl = 128; m_sc = 0; m_dc = 0; m_sym = 0;
      return;
    end
    acq  = m[1];
    step = acq && (m == 2'b11 || m_sc == SDIV-1);
    dec  = acq && (m_dc == DDIV-1);
    run  = acq && !inh;
    gap2 = (m_pk - m_vl) >= 2;
    npk = m_pk; nvl = m_vl;
    if (run && step && apk)      npk = (m_pk < 255) ? m_pk + 1 : 255;
    else if (run && dec && gap2) npk = m_pk - 1;
    if (run && step && !avl)     nvl = (m_vl > 0) ? m_vl - 1 : 0;
    else if (run && dec && gap2) nvl = m_vl + 1;
    m_pk = npk; m_vl = nvl;
    if (!avl)      m_sym = 0;
    else if (apk)  m_sym = 3;
    else if (actr) m_sym = 2;
    else           m_sym = 1;
    if (acq) begin
      m_sc = (m_sc + 1) % SDIV;
      m_dc = (m_dc + 1) % DDIV;
    end
  endtask

  task automatic cyc(input logic [1:0] m, input bit inh, apk, actr, avl, input string tag);
    mode_sel = m; trk_inh = inh; above_pk = apk; above_ctr = actr; above_vl = avl;
    @(posedge clk);
    model_edge(m, inh, apk, actr, avl);
    @(negedge clk);
    check(tag, "pk_lvl", pk_lvl, m_pk);
    check(tag, "vl_lvl", vl_lvl, m_vl);
    check("R11", "ctr_lvl", ctr_lvl, (m_pk + m_vl) / 2);
    check("R10", "sym", {sym_hi, sym_lo}, m_sym);
  endtask

  typedef struct packed { logic apk; logic actr; logic avl; logic [1:0] sym; } vec_t;
  localparam vec_t SYM_TBL [8] = '{
    '{1'b0, 1'b0, 1'b0, 2'b00}, '{1'b0, 1'b1, 1'b0, 2'b00},
    '{1'b1, 1'b0, 1'b0, 2'b00}, '{1'b0, 1'b0, 1'b1, 2'b01},
    '{1'b0, 1'b1, 1'b1, 2'b10}, '{1'b1, 1'b0, 1'b1, 2'b11},
    '{1'b1, 1'b1, 1'b1, 2'b11}, '{1'b0, 1'b1, 1'b1, 2'b10}
  };

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pk_save, vl_save;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pk_lvl", pk_lvl, 128);
    check("R1", "vl_lvl", vl_lvl, 128);
    check("R1", "ctr_lvl", ctr_lvl, 128);
    check("R1", "sym", {sym_hi, sym_lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: symbol table walked in hold mode
    for (int i = 0; i < 8; i++) begin
      cyc(2'b01, 1'b0, SYM_TBL[i].apk, SYM_TBL[i].actr, SYM_TBL[i].avl, "R10");
      check("R10", "table sym", {sym_hi, sym_lo}, SYM_TBL[i].sym);
    end

    // R4: slow mode steps only on every SDIV-th edge
    cyc(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < SDIV - 1; i++) cyc(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, "R4");
    check("R4", "pk before first slow step", pk_lvl, 128);
    cyc(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, "R4");
    check("R4", "pk at first slow step", pk_lvl, 129);
    for (int i = 0; i < 12; i++) cyc(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, "R4");

    // R3 / R8: fast ramp into both rails
    for (int i = 0; i < 140; i++) cyc(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    check("R8", "pk at rail", pk_lvl, 255);
    check("R8", "vl at rail", vl_lvl, 0);

    // R6: hold freezes levels even with outward comparator results
    pk_save = pk_lvl; vl_save = vl_lvl;
    for (int i = 0; i < 40; i++) cyc(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    check("R6", "pk after hold", pk_lvl, pk_save);

    // R7: inhibit freezes levels through decay ticks
    for (int i = 0; i < 40; i++) cyc(2'b11, 1'b1, 1'b0, 1'b1, 1'b1, "R7");
    check("R7", "pk under inhibit", pk_lvl, pk_save);
    check("R7", "vl under inhibit", vl_lvl, vl_save);

    // R5 / R9: full-range inward decay until the gap closes
    for (int i = 0; i < 2100; i++) cyc(2'b11, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    check("R5", "gap after decay", ((pk_lvl - vl_lvl) <= 1) ? 1 : 0, 1);
    check("R9", "pk not below vl", (pk_lvl >= vl_lvl) ? 1 : 0, 1);

    // R2: standby parks levels and clears symbol
    cyc(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
    cyc(2'b00, 1'b0, 1'b1, 1'b1, 1'b1, "R2");
    check("R2", "pk parked", pk_lvl, 128);
    check("R2", "sym cleared", {sym_hi, sym_lo}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule